// File: doc/BRIEF.md
# PDM Microphone Capture Front End

This block turns the one-bit pulse-density stream of one or two digital microphones into signed 24-bit PCM samples. Both microphones share a single data line and a bit clock. One drives the line on the rising half of the clock and the other on the falling half. The surrounding logic synchronises the bit clock into the system clock domain. It then hands the block a one-cycle strobe for each rising and each falling bit-clock edge, and the block samples the data line on those strobes.

A swap input decides which edge carries the left microphone. Each microphone stream feeds its own fourth-order CIC decimator. The decimation ratio is 64, 128 or 256 bit-clock periods per output sample. The CIC result is scaled to the PCM range by an arithmetic shift that depends on that ratio. It is then multiplied by a Q23 gain derived from a percentage boost setting, and saturated to 24 bits.

A mode input selects one of three outputs: the left microphone alone, the right microphone alone, or both. Both channels of an output sample leave the block in the same cycle, marked by a one-cycle valid pulse.

Top module: `pdm_capture_top`

## Requirements
- R1: `osr_sel` sets the decimation ratio: 0 gives 64, 1 gives 128, 2 gives 256, and 3 behaves as 2. A frame counter advances on each falling-edge strobe. Exactly one output sample is produced per ratio-many bit-clock periods counted from reset.
- R2: With `edge_swap` = 0, the left microphone is sampled on rising-edge strobes and the right on falling-edge strobes. With `edge_swap` = 1 the two edges trade roles.
- R3: `chan_sel` encoding is 0 = left only, 1 = right only, 2 = stereo, and 3 behaves as stereo. In stereo, `pcm_ch0` carries left and `pcm_ch1` carries right. In the two single-channel modes, `pcm_ch0` carries the selected microphone and `pcm_ch1` is 0.
- R4: A data bit of 1 counts as +1 and a bit of 0 counts as -1. Each channel is decimated by a fourth-order CIC. For a steady periodic stream whose period divides the ratio, with a fraction d of ones, the settled pre-gain level is (2d-1)·2^23.
- R5: The gain is 0x800000 (unity) when `boost` is 0. Otherwise it is floor(0x800000·boost/100). The output is floor(level·gain/2^23).
- R6: The scaled product saturates to the range -8388608 to 8388607 and never wraps.
- R7: `pcm_valid` is a single-cycle pulse, once per output sample. Both channel outputs are updated together in that pulse's cycle.
- R8: During and immediately after reset, `pcm_valid` is low and both channel outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pdm_dat | input | 1 | Shared PDM data line, synchronised |
| pdm_rise | input | 1 | One-cycle strobe at each rising bit-clock edge |
| pdm_fall | input | 1 | One-cycle strobe at each falling bit-clock edge |
| osr_sel | input | 2 | Decimation ratio code |
| chan_sel | input | 2 | Output channel mode |
| edge_swap | input | 1 | 0: left on rising edge; 1: left on falling edge |
| boost | input | 12 | Gain in percent; 0 means unity |
| pcm_valid | output | 1 | Output sample strobe |
| pcm_ch0 | output | 24 | First output channel, signed |
| pcm_ch1 | output | 24 | Second output channel, signed; 0 in single-channel modes |

## Verification
Two things land in the same cycle. The two channels are presented together, and saturation may act on one channel while the other stays in range. The bench provokes this by driving a full-scale density on the rising-edge half of the line and an opposite or mid-scale density on the falling-edge half. It then checks both channel words of the same valid pulse against independently computed levels. Swapping the edge assignment or boosting the gain past full scale must move the clipping to the correct channel without disturbing the other one.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    localparam int PCM_W       = 24;
    localparam int Q_FRAC      = 23;
    localparam int BOOST_W     = 12;
    localparam int GAIN_W      = PCM_W + BOOST_W - 6;
    localparam int CIC_N       = 4;
    localparam int OSR_LOG_MIN = 6;
    localparam int OSR_LOG_MAX = 8;
    localparam int CIC_W       = 2 + CIC_N * OSR_LOG_MAX;
    localparam int PRE_W       = PCM_W + 1;
    localparam int PROD_W      = PRE_W + GAIN_W + 1;

    localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << Q_FRAC;

    localparam logic signed [PROD_W-1:0] SAT_HI =
        $signed({{(PROD_W-PCM_W+1){1'b0}}, {(PCM_W-1){1'b1}}});
    localparam logic signed [PROD_W-1:0] SAT_LO =
        $signed({{(PROD_W-PCM_W+1){1'b1}}, {(PCM_W-1){1'b0}}});

    typedef enum logic [1:0] {
        CH_LEFT   = 2'd0,
        CH_RIGHT  = 2'd1,
        CH_STEREO = 2'd2,
        CH_BOTH_X = 2'd3
    } chan_mode_e;

    typedef struct packed {
        logic signed [PRE_W-1:0] first;
        logic signed [PRE_W-1:0] second;
    } pcm_route_t;

    function automatic int osr_log(input logic [1:0] code);
        return OSR_LOG_MIN + ((code > 2'd2) ? 2 : int'(code));
    endfunction

    function automatic int cic_shift(input logic [1:0] code);
        return CIC_N * osr_log(code) - (PCM_W - 1);
    endfunction

    function automatic logic [GAIN_W-1:0] boost_to_gain(input logic [BOOST_W-1:0] b);
        logic [Q_FRAC+BOOST_W:0] scaled;
        if (b == '0) begin
            return GAIN_UNITY;
        end
        scaled = (Q_FRAC + BOOST_W + 1)'(b) << Q_FRAC;
        return GAIN_W'(scaled / 100);
    endfunction

    function automatic logic signed [PCM_W-1:0] sat_pcm(input logic signed [PROD_W-1:0] v);
        if (v > SAT_HI) begin
            return SAT_HI[PCM_W-1:0];
        end
        if (v < SAT_LO) begin
            return SAT_LO[PCM_W-1:0];
        end
        return v[PCM_W-1:0];
    endfunction

endpackage

// File: rtl/pdm_cic.sv
module pdm_cic
    import pdm_cap_pkg::*;
#(
    parameter int N = CIC_N,
    parameter int W = CIC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_en,
    input  logic                smp_bit,
    input  logic                dump,
    output logic signed [W-1:0] y
);

    logic signed [W-1:0] acc    [N];
    logic signed [W-1:0] dly    [N];
    logic signed [W-1:0] stg_in [N];
    logic signed [W-1:0] comb_out;
    logic signed [W-1:0] step;

    assign step = smp_bit ? W'(1) : {W{1'b1}};

    always_comb begin
        logic signed [W-1:0] t;
        t = acc[N-1];
        for (int k = 0; k < N; k++) begin
            stg_in[k] = t;
            t         = t - dly[k];
        end
        comb_out = t;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) begin
                acc[k] <= '0;
                dly[k] <= '0;
            end
            y <= '0;
        end else begin
            if (smp_en) begin
                acc[0] <= acc[0] + step;
                for (int k = 1; k < N; k++) begin
                    acc[k] <= acc[k] + acc[k-1];
                end
            end
            if (dump) begin
                for (int k = 0; k < N; k++) begin
                    dly[k] <= stg_in[k];
                end
                y <= comb_out;
            end
        end
    end

endmodule

// File: rtl/pdm_gain.sv
module pdm_gain
    import pdm_cap_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [PRE_W-1:0] x,
    input  logic [GAIN_W-1:0]       g,
    output logic signed [PCM_W-1:0] y
);

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;

    assign prod    = $signed(x) * $signed({1'b0, g});
    assign prod_sh = prod >>> Q_FRAC;

    always_ff @(posedge clk) begin
        if (rst) begin
            y <= '0;
        end else if (en) begin
            y <= sat_pcm(prod_sh);
        end
    end

    // R5
    unity_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (en && g == GAIN_UNITY && x[PRE_W-1] == x[PRE_W-2])
        |=> (y == $past(x[PCM_W-1:0])));

endmodule

// File: rtl/pdm_capture_top.sv
module pdm_capture_top
    import pdm_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               pdm_dat,
    input  logic               pdm_rise,
    input  logic               pdm_fall,
    input  logic [1:0]         osr_sel,
    input  logic [1:0]         chan_sel,
    input  logic               edge_swap,
    input  logic [BOOST_W-1:0] boost,
    output logic               pcm_valid,
    output logic [PCM_W-1:0]   pcm_ch0,
    output logic [PCM_W-1:0]   pcm_ch1
);

    localparam int N_MIC = 2;

    logic                   left_en;
    logic                   right_en;
    logic [OSR_LOG_MAX-1:0] frame_cnt;
    logic [OSR_LOG_MAX-1:0] frame_lim;
    logic                   dump_q;
    logic                   stage_v;
    logic [GAIN_W-1:0]      gain_q;
    chan_mode_e             mode;
    pcm_route_t             route;
    logic signed [PRE_W-1:0] mic_pre [N_MIC];
    logic signed [PCM_W-1:0] out0;
    logic signed [PCM_W-1:0] out1;

    assign left_en   = edge_swap ? pdm_fall : pdm_rise;
    assign right_en  = edge_swap ? pdm_rise : pdm_fall;
    assign frame_lim = OSR_LOG_MAX'((1 << osr_log(osr_sel)) - 1);
    assign mode      = chan_mode_e'(chan_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
            dump_q    <= 1'b0;
            stage_v   <= 1'b0;
            pcm_valid <= 1'b0;
            gain_q    <= GAIN_UNITY;
        end else begin
            gain_q    <= boost_to_gain(boost);
            stage_v   <= dump_q;
            pcm_valid <= stage_v;
            dump_q    <= 1'b0;
            if (pdm_fall) begin
                if (frame_cnt >= frame_lim) begin
                    frame_cnt <= '0;
                    dump_q    <= 1'b1;
                end else begin
                    frame_cnt <= frame_cnt + 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < N_MIC; c++) begin : g_mic
        logic                    smp;
        logic signed [CIC_W-1:0] cic_y;

        assign smp = (c == 0) ? left_en : right_en;

        pdm_cic #(.N(CIC_N), .W(CIC_W)) u_cic (
            .clk     (clk),
            .rst     (rst),
            .smp_en  (smp),
            .smp_bit (pdm_dat),
            .dump    (dump_q),
            .y       (cic_y)
        );

        assign mic_pre[c] = PRE_W'(cic_y >>> cic_shift(osr_sel));
    end

    always_comb begin
        route.first  = (mode == CH_RIGHT) ? mic_pre[1] : mic_pre[0];
        route.second = (mode == CH_LEFT || mode == CH_RIGHT) ? '0 : mic_pre[1];
    end

    pdm_gain u_gain0 (
        .clk (clk),
        .rst (rst),
        .en  (stage_v),
        .x   (route.first),
        .g   (gain_q),
        .y   (out0)
    );

    pdm_gain u_gain1 (
        .clk (clk),
        .rst (rst),
        .en  (stage_v),
        .x   (route.second),
        .g   (gain_q),
        .y   (out1)
    );

    assign pcm_ch0 = out0;
    assign pcm_ch1 = out1;

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |=> !pcm_valid);

    // R1
    out_latency_chk: assert property (@(posedge clk) disable iff (rst)
        pcm_valid |-> $past(dump_q, 2));

    // R3
    mono_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (pcm_valid && ($past(chan_sel) == 2'd0 || $past(chan_sel) == 2'd1))
        |-> (pcm_ch1 == '0));

    // R8
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!pcm_valid && pcm_ch0 == '0 && pcm_ch1 == '0));

endmodule

// File: tb/tb_pdm_capture_top.sv
`timescale 1ns/1ps
module tb_pdm_capture_top;
    import pdm_cap_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               pdm_dat = 1'b0;
    logic               pdm_rise = 1'b0;
    logic               pdm_fall = 1'b0;
    logic [1:0]         osr_sel = 2'd0;
    logic [1:0]         chan_sel = 2'd2;
    logic               edge_swap = 1'b0;
    logic [BOOST_W-1:0] boost = '0;
    logic               pcm_valid;
    logic [PCM_W-1:0]   pcm_ch0;
    logic [PCM_W-1:0]   pcm_ch1;

    always #2.5 clk = ~clk;

    pdm_capture_top dut (
        .clk       (clk),
        .rst       (rst),
        .pdm_dat   (pdm_dat),
        .pdm_rise  (pdm_rise),
        .pdm_fall  (pdm_fall),
        .osr_sel   (osr_sel),
        .chan_sel  (chan_sel),
        .edge_swap (edge_swap),
        .boost     (boost),
        .pcm_valid (pcm_valid),
        .pcm_ch0   (pcm_ch0),
        .pcm_ch1   (pcm_ch1)
    );

    typedef struct {
        int    ch0;
        int    ch1;
        bit    chk;
        string req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic prev_v = 1'b0;

    localparam int OUTS   = 9;
    localparam int SETTLE = 5;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    function automatic int mic_level(input bit [3:0] pat);
        return ($countones(pat) * 2 - 4) * (1 << 21);
    endfunction

    function automatic int apply_gain(input int x, input int b);
        longint g;
        longint p;
        g = (b == 0) ? 64'sd8388608 : (64'sd8388608 * b) / 100;
        p = (longint'(x) * g) >>> 23;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return int'(p);
    endfunction

    task automatic check_int(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pops expected items on each valid pulse
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_v) begin
                // R7: pulse is one cycle wide
                check_int("R7", "valid width", int'(pcm_valid), 0);
            end
            if (pcm_valid) begin
                if (q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1 extra output actual 1 expected 0");
                end else begin
                    exp_t e;
                    int   a0;
                    int   a1;
                    e  = q.pop_front();
                    a0 = $signed(pcm_ch0);
                    a1 = $signed(pcm_ch1);
                    if (e.chk) begin
                        check_int(e.req, "ch0", a0, e.ch0);
                        check_int(e.req, "ch1", a1, e.ch1);
                    end
                end
            end
            prev_v <= pcm_valid;
        end else begin
            prev_v <= 1'b0;
        end
    end

    task automatic run_case(input int osr, input int mode, input int swap, input int bst,
                            input bit [3:0] rpat, input bit [3:0] fpat, input string req);
        int ratio;
        int lvl_l;
        int lvl_r;
        int e0;
        int e1;
        ratio = 64 << ((osr > 2) ? 2 : osr);
        @(negedge clk);
        rst       = 1'b1;
        osr_sel   = 2'(osr);
        chan_sel  = 2'(mode);
        edge_swap = swap[0];
        boost     = BOOST_W'(bst);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        lvl_l = (swap == 0) ? mic_level(rpat) : mic_level(fpat);
        lvl_r = (swap == 0) ? mic_level(fpat) : mic_level(rpat);
        if (mode == 0) begin
            e0 = lvl_l; e1 = 0;
        end else if (mode == 1) begin
            e0 = lvl_r; e1 = 0;
        end else begin
            e0 = lvl_l; e1 = lvl_r;
        end
        for (int i = 0; i < OUTS; i++) begin
            exp_t e;
            e.ch0 = apply_gain(e0, bst);
            e.ch1 = apply_gain(e1, bst);
            e.chk = (i >= SETTLE);
            e.req = req;
            q.push_back(e);
        end
        for (int p = 0; p < OUTS * ratio; p++) begin
            pdm_dat  = rpat[3 - (p % 4)];
            pdm_rise = 1'b1;
            @(negedge clk);
            pdm_rise = 1'b0;
            @(negedge clk);
            pdm_dat  = fpat[3 - (p % 4)];
            pdm_fall = 1'b1;
            @(negedge clk);
            pdm_fall = 1'b0;
            @(negedge clk);
        end
        repeat (12) @(negedge clk);
        // R1: exactly OUTS outputs for OUTS*ratio bit periods
        check_int("R1", "missing outputs", q.size(), 0);
        q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R8: reset state, with strobes active during reset
        pdm_rise = 1'b1;
        pdm_dat  = 1'b1;
        repeat (4) @(negedge clk);
        pdm_rise = 1'b0;
        check_int("R8", "valid in reset", int'(pcm_valid), 0);
        check_int("R8", "ch0 in reset", int'(pcm_ch0), 0);
        check_int("R8", "ch1 in reset", int'(pcm_ch1), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_int("R8", "valid after reset", int'(pcm_valid), 0);
        check_int("R8", "ch0 after reset", int'(pcm_ch0), 0);

        // R2 R3 R6: rising mic full scale up, falling mic full scale down
        run_case(0, 2, 0, 0, 4'b1111, 4'b0000, "R2 R3 R6");
        // R2: swapped edges swap the channels
        run_case(0, 2, 1, 0, 4'b1111, 4'b0000, "R2 R6");
        // R4: three-quarter and half density at ratio 128
        run_case(1, 2, 0, 0, 4'b1110, 4'b1010, "R4 R1");
        // R5: boost 150 at ratio 256
        run_case(2, 2, 0, 150, 4'b1110, 4'b1000, "R5 R4");
        // R1 R3: code 3 acts as 256, left only
        run_case(3, 0, 0, 0, 4'b1000, 4'b1111, "R1 R3");
        // R3 R6: right only, boost 200 clips
        run_case(0, 1, 0, 200, 4'b0000, 4'b1110, "R3 R6");
        // R3 R5: mode 3 as stereo, swapped, boost 33
        run_case(0, 3, 1, 33, 4'b1000, 4'b1110, "R3 R5 R2");
        // R3: left only with swap, zero level
        run_case(1, 0, 1, 0, 4'b1111, 4'b1100, "R3 R2");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule